// File: doc/BRIEF.md
# Bit-Array Mismatch Scanner

This block holds two equal-length bit arrays, a live sample array and an expected-pattern array. It walks them one position per clock and records the index of every position where they differ into a small result buffer. A level `enable` input starts and releases a scan, much like a rung condition. A new scan starts only on a rising edge of `enable`. Completion state stays up until `enable` is taken low again.

The `inhibit` input selects the search mode. With `inhibit` high, each rising edge of `enable` advances to the next difference only and then stops. With `inhibit` low, one pass covers the whole array. A per-instance parameter, `UPDATE_REF`, makes the engine copy the sample bit into the expected array at each difference found. The expected pattern then tracks changing conditions.

Both arrays are filled one bit per cycle through load ports and read back through registered read ports. The result buffer also has a registered read port. Status is presented as two 16-bit words, alongside the compare position and the result count.

Top module: `bitfile_diff_scan`

## Requirements
- R1: After reset, `ctl_word`, `res_word`, `cmp_pos`, `res_cnt` and `busy` are all 0.
- R2: `ctl_word` bit 15 shows `enable` as sampled on the previous clock, bit 13 is compare-done and bit 8 is found. `res_word` bit 13 is result-full. Every other bit of both words is 0.
- R3: With `inhibit`=1, an `enable` rising edge scans forward from `cmp_pos` = s. At the first differing position p it stops. It then sets found, writes p to result entry `res_cnt`, increments `res_cnt` and leaves `cmp_pos` = p+1. Found appears p−s+2 clocks after `enable` is first sampled high.
- R4: When `enable` is low and the engine is not scanning, found reads 0 one clock later. A scan that has not reached the end keeps `cmp_pos` and `res_cnt` across the low phase.
- R5: Compare-done sets when the position reaches LEN, and `cmp_pos` reads LEN whenever compare-done is set. In single-step mode, found at completion reflects only the last position examined.
- R6: With `inhibit`=0, one run stores all differing positions in ascending order from the current result index. Done appears LEN+1 clocks after `enable` is first sampled high from position 0. Found is then set if and only if at least one difference was seen during the run.
- R7: When no position differs, the run ends with done=1, found=0 and `res_cnt`=0, and every result entry keeps its old value.
- R8: With `UPDATE_REF`=1, the expected-array bit at each differing position becomes the sample bit. With `UPDATE_REF`=0, the expected array is never written by the engine. Array and result read ports return data one clock after the address is presented.
- R9: If `res_cnt` reaches RES_DEPTH before the end, the engine halts with busy=0, result-full=1 and done=0. The next `enable` rising edge resets `res_cnt` to 0 and clears result-full, and new positions overwrite entries from index 0. Entries not rewritten are kept, and `res_cnt` never exceeds RES_DEPTH.
- R10: When `enable` is low while done is set, the next clock clears both status words, `cmp_pos` and `res_cnt`.
- R11: `busy` is high exactly while scanning, `cmp_pos` advances by one on every busy clock, and `busy` and done are never high together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Level run condition; rising edge starts or resumes a scan |
| inhibit | input | 1 | 1: stop at each difference; 0: full pass |
| src_ld_en | input | 1 | Write `src_ld_bit` into the sample array |
| src_ld_bit | input | 1 | Sample bit to load |
| ref_ld_en | input | 1 | Write `ref_ld_bit` into the expected array |
| ref_ld_bit | input | 1 | Expected bit to load |
| ld_addr | input | $clog2(LEN) | Bit position for both load ports |
| arr_rd_addr | input | $clog2(LEN) | Read position for both arrays |
| src_rd_bit | output | 1 | Registered sample-array read |
| ref_rd_bit | output | 1 | Registered expected-array read |
| res_rd_addr | input | $clog2(RES_DEPTH) | Result buffer read index |
| res_rd_pos | output | $clog2(LEN) | Registered result entry |
| ctl_word | output | 16 | Enable status (15), compare-done (13), found (8) |
| res_word | output | 16 | Result-full (13) |
| cmp_pos | output | $clog2(LEN)+1 | Compare position counter |
| res_cnt | output | $clog2(RES_DEPTH+1) | Result counter |
| busy | output | 1 | Scan in progress |

## Verification
Every result is due a fixed number of rising edges after the stimulus. One edge registers `enable` and turns a rising edge into the scan state. Each further edge examines one position, so a difference at p from start s appears after p−s+2 edges and a full clean pass after LEN+1. Release clearing takes one edge, and all read ports take one edge. The bench drives on the falling edge and samples on the falling edge after exactly that many rising edges. Where timing is the point, it also checks the edge before, to show the result has not arrived early.

// File: rtl/bfd_pkg.sv
package bfd_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SCAN = 2'd1,
    ST_HOLD = 2'd2,
    ST_DONE = 2'd3
  } scan_st_t;

  localparam int CTL_EN_BIT    = 15;
  localparam int CTL_DONE_BIT  = 13;
  localparam int CTL_FOUND_BIT = 8;
  localparam int RES_FULL_BIT  = 13;
endpackage

// File: rtl/bfd_bitarr.sv
module bfd_bitarr #(
  parameter int LEN = 64,
  parameter int AW  = $clog2(LEN)
) (
  input  logic          clk,
  input  logic          ld_en,
  input  logic [AW-1:0] ld_addr,
  input  logic          ld_bit,
  input  logic          fix_en,
  input  logic [AW-1:0] fix_addr,
  input  logic          fix_bit,
  input  logic [AW-1:0] probe_addr,
  output logic          probe_bit,
  input  logic [AW-1:0] rd_addr,
  output logic          rd_bit
);
  logic [LEN-1:0] bits_q;

  // host load wins over an engine fix in the same cycle
  always_ff @(posedge clk) begin
    if (ld_en) begin
      bits_q[ld_addr] <= ld_bit;
    end else if (fix_en) begin
      bits_q[fix_addr] <= fix_bit;
    end
    rd_bit <= bits_q[rd_addr];
  end

  assign probe_bit = bits_q[probe_addr];
endmodule

// File: rtl/bfd_resbuf.sv
module bfd_resbuf #(
  parameter int DEPTH = 8,
  parameter int PW    = 6,
  parameter int IW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [IW-1:0] waddr,
  input  logic [PW-1:0] wdata,
  input  logic [IW-1:0] raddr,
  output logic [PW-1:0] rdata
);
  logic [PW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr] <= wdata;
    end
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/bfd_engine.sv
module bfd_engine
  import bfd_pkg::*;
#(
  parameter int LEN   = 64,
  parameter int DEPTH = 8,
  parameter int PW    = $clog2(LEN),
  parameter int IW    = $clog2(DEPTH),
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          enable,
  input  logic          inhibit,
  input  logic          src_bit,
  input  logic          ref_bit,
  output logic [PW-1:0] probe_addr,
  output logic          hit_we,
  output logic [IW-1:0] hit_idx,
  output logic [PW-1:0] hit_pos,
  output logic          en_q,
  output logic          done_q,
  output logic          found_q,
  output logic          full_q,
  output logic [PW:0]   pos_q,
  output logic [CW-1:0] cnt_q,
  output logic          busy
);
  localparam logic [PW:0]   POS_LAST = (PW+1)'(LEN - 1);
  localparam logic [CW-1:0] CNT_LAST = CW'(DEPTH - 1);

  scan_st_t st_q;
  logic     any_q;
  logic     rise;
  logic     diff;
  logic     at_last;
  logic     fills;

  assign rise    = enable & ~en_q;
  assign diff    = src_bit ^ ref_bit;
  assign at_last = (pos_q == POS_LAST);
  assign fills   = (cnt_q == CNT_LAST);

  assign probe_addr = pos_q[PW-1:0];
  assign hit_we     = (st_q == ST_SCAN) && diff;
  assign hit_idx    = cnt_q[IW-1:0];
  assign hit_pos    = pos_q[PW-1:0];
  assign busy       = (st_q == ST_SCAN);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= ST_IDLE;
      en_q    <= 1'b0;
      done_q  <= 1'b0;
      found_q <= 1'b0;
      full_q  <= 1'b0;
      any_q   <= 1'b0;
      pos_q   <= '0;
      cnt_q   <= '0;
    end else begin
      en_q <= enable;
      unique case (st_q)
        ST_IDLE: begin
          if (rise) st_q <= ST_SCAN;
        end
        ST_SCAN: begin
          pos_q <= pos_q + 1'b1;
          if (diff) begin
            cnt_q <= cnt_q + 1'b1;
            any_q <= 1'b1;
            if (fills) full_q <= 1'b1;
          end
          if (at_last) begin
            st_q    <= ST_DONE;
            done_q  <= 1'b1;
            found_q <= inhibit ? diff : (any_q | diff);
          end else if (diff && (inhibit || fills)) begin
            st_q    <= ST_HOLD;
            found_q <= inhibit;
          end
        end
        ST_HOLD: begin
          if (!enable) begin
            found_q <= 1'b0;
          end else if (rise) begin
            st_q <= ST_SCAN;
            if (full_q) begin
              cnt_q  <= '0;
              full_q <= 1'b0;
            end
          end
        end
        ST_DONE: begin
          if (!enable) begin
            st_q    <= ST_IDLE;
            done_q  <= 1'b0;
            found_q <= 1'b0;
            full_q  <= 1'b0;
            any_q   <= 1'b0;
            pos_q   <= '0;
            cnt_q   <= '0;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/bitfile_diff_scan.sv
module bitfile_diff_scan
  import bfd_pkg::*;
#(
  parameter int LEN        = 64,
  parameter int RES_DEPTH  = 8,
  parameter bit UPDATE_REF = 1'b0,
  localparam int PW = $clog2(LEN),
  localparam int IW = $clog2(RES_DEPTH),
  localparam int CW = $clog2(RES_DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          enable,
  input  logic          inhibit,
  input  logic          src_ld_en,
  input  logic          src_ld_bit,
  input  logic          ref_ld_en,
  input  logic          ref_ld_bit,
  input  logic [PW-1:0] ld_addr,
  input  logic [PW-1:0] arr_rd_addr,
  output logic          src_rd_bit,
  output logic          ref_rd_bit,
  input  logic [IW-1:0] res_rd_addr,
  output logic [PW-1:0] res_rd_pos,
  output logic [15:0]   ctl_word,
  output logic [15:0]   res_word,
  output logic [PW:0]   cmp_pos,
  output logic [CW-1:0] res_cnt,
  output logic          busy
);
  logic [PW-1:0] probe_addr;
  logic          src_probe;
  logic          ref_probe;
  logic          hit_we;
  logic [IW-1:0] hit_idx;
  logic [PW-1:0] hit_pos;
  logic          ref_fix_en;
  logic          en_q, done_q, found_q, full_q;

  generate
    if (UPDATE_REF) begin : g_track
      assign ref_fix_en = hit_we;
    end else begin : g_fixed
      assign ref_fix_en = 1'b0;
    end
  endgenerate

  bfd_bitarr #(.LEN(LEN), .AW(PW)) u_src (
    .clk(clk), .ld_en(src_ld_en), .ld_addr(ld_addr), .ld_bit(src_ld_bit),
    .fix_en(1'b0), .fix_addr('0), .fix_bit(1'b0),
    .probe_addr(probe_addr), .probe_bit(src_probe),
    .rd_addr(arr_rd_addr), .rd_bit(src_rd_bit)
  );

  bfd_bitarr #(.LEN(LEN), .AW(PW)) u_ref (
    .clk(clk), .ld_en(ref_ld_en), .ld_addr(ld_addr), .ld_bit(ref_ld_bit),
    .fix_en(ref_fix_en), .fix_addr(probe_addr), .fix_bit(src_probe),
    .probe_addr(probe_addr), .probe_bit(ref_probe),
    .rd_addr(arr_rd_addr), .rd_bit(ref_rd_bit)
  );

  bfd_resbuf #(.DEPTH(RES_DEPTH), .PW(PW), .IW(IW)) u_res (
    .clk(clk), .we(hit_we), .waddr(hit_idx), .wdata(hit_pos),
    .raddr(res_rd_addr), .rdata(res_rd_pos)
  );

  bfd_engine #(.LEN(LEN), .DEPTH(RES_DEPTH), .PW(PW), .IW(IW), .CW(CW)) u_eng (
    .clk(clk), .rst(rst), .enable(enable), .inhibit(inhibit),
    .src_bit(src_probe), .ref_bit(ref_probe),
    .probe_addr(probe_addr), .hit_we(hit_we), .hit_idx(hit_idx), .hit_pos(hit_pos),
    .en_q(en_q), .done_q(done_q), .found_q(found_q), .full_q(full_q),
    .pos_q(cmp_pos), .cnt_q(res_cnt), .busy(busy)
  );

  always_comb begin
    ctl_word = '0;
    ctl_word[CTL_EN_BIT]    = en_q;
    ctl_word[CTL_DONE_BIT]  = done_q;
    ctl_word[CTL_FOUND_BIT] = found_q;
    res_word = '0;
    res_word[RES_FULL_BIT]  = full_q;
  end
endmodule

// File: rtl/bfd_chk.sv
module bfd_chk #(
  parameter int LEN       = 64,
  parameter int RES_DEPTH = 8,
  localparam int PW = $clog2(LEN),
  localparam int CW = $clog2(RES_DEPTH + 1)
) (
  input logic          clk,
  input logic          rst,
  input logic          enable,
  input logic [15:0]   ctl_word,
  input logic [15:0]   res_word,
  input logic [PW:0]   cmp_pos,
  input logic [CW-1:0] res_cnt,
  input logic          busy
);
  localparam logic [PW:0]   POS_END = (PW+1)'(LEN);
  localparam logic [CW-1:0] CNT_MAX = CW'(RES_DEPTH);

  assert_word_layout_R2: assert property (@(posedge clk) disable iff (rst)
    ((ctl_word & 16'h5EFF) == 16'h0000) && ((res_word & 16'hDFFF) == 16'h0000));

  assert_found_drop_R4: assert property (@(posedge clk) disable iff (rst)
    (!enable && !busy) |=> !ctl_word[8]);

  assert_done_at_end_R5: assert property (@(posedge clk) disable iff (rst)
    ctl_word[13] |-> (cmp_pos == POS_END));

  assert_no_overflow_R9: assert property (@(posedge clk) disable iff (rst)
    res_cnt <= CNT_MAX);

  assert_full_halts_R9: assert property (@(posedge clk) disable iff (rst)
    res_word[13] |-> !busy);

  assert_release_clear_R10: assert property (@(posedge clk) disable iff (rst)
    (ctl_word[13] && !enable) |=>
      (ctl_word == 16'h0000 && res_word == 16'h0000 && cmp_pos == '0 && res_cnt == '0));

  assert_busy_range_R11: assert property (@(posedge clk) disable iff (rst)
    busy |-> (cmp_pos < POS_END && !ctl_word[13]));

  assert_busy_step_R11: assert property (@(posedge clk) disable iff (rst)
    busy |=> (cmp_pos == $past(cmp_pos) + 1'b1));
endmodule

bind bitfile_diff_scan bfd_chk #(.LEN(LEN), .RES_DEPTH(RES_DEPTH)) u_chk (
  .clk(clk), .rst(rst), .enable(enable), .ctl_word(ctl_word), .res_word(res_word),
  .cmp_pos(cmp_pos), .res_cnt(res_cnt), .busy(busy)
);

// File: tb/test_bitfile_diff_scan.sv
`timescale 1ns/1ps
module test_bitfile_diff_scan;
  localparam int LEN = 64;
  localparam int DEP = 8;
  localparam int PW  = 6;
  localparam int IW  = 3;
  localparam int CW  = 4;
  localparam int NV  = 5;

  // vector table: sample mask (expected array all zero), count, first, last
  localparam logic [63:0] V_MASK [NV] = '{64'h0, 64'h1, 64'h8000_0000_0000_0000,
                                         64'h0000_0100_0002_0020, 64'h7F00_0000_0000_0000};
  localparam int V_CNT   [NV] = '{0, 1, 1, 3, 7};
  localparam int V_FIRST [NV] = '{0, 0, 63, 5, 56};
  localparam int V_LAST  [NV] = '{0, 0, 63, 40, 62};

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic enable = 1'b0, inhibit = 1'b0;
  logic src_ld_en = 1'b0, src_ld_bit = 1'b0, ref_ld_en = 1'b0, ref_ld_bit = 1'b0;
  logic [PW-1:0] ld_addr = '0, arr_rd_addr = '0;
  logic [IW-1:0] res_rd_addr = '0;
  logic src_rd_bit, ref_rd_bit, busy, src_rd_bit_u, ref_rd_bit_u, busy_u;
  logic [PW-1:0] res_rd_pos, res_rd_pos_u;
  logic [15:0] ctl_word, res_word, ctl_word_u, res_word_u;
  logic [PW:0] cmp_pos, cmp_pos_u;
  logic [CW-1:0] res_cnt, res_cnt_u;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  bitfile_diff_scan #(.LEN(LEN), .RES_DEPTH(DEP), .UPDATE_REF(1'b0)) i_bitfile_diff_scan (
    .clk(clk), .rst(rst), .enable(enable), .inhibit(inhibit),
    .src_ld_en(src_ld_en), .src_ld_bit(src_ld_bit), .ref_ld_en(ref_ld_en), .ref_ld_bit(ref_ld_bit),
    .ld_addr(ld_addr), .arr_rd_addr(arr_rd_addr), .src_rd_bit(src_rd_bit), .ref_rd_bit(ref_rd_bit),
    .res_rd_addr(res_rd_addr), .res_rd_pos(res_rd_pos), .ctl_word(ctl_word), .res_word(res_word),
    .cmp_pos(cmp_pos), .res_cnt(res_cnt), .busy(busy)
  );

  bitfile_diff_scan #(.LEN(LEN), .RES_DEPTH(DEP), .UPDATE_REF(1'b1)) i_bitfile_diff_scan_upd (
    .clk(clk), .rst(rst), .enable(enable), .inhibit(inhibit),
    .src_ld_en(src_ld_en), .src_ld_bit(src_ld_bit), .ref_ld_en(ref_ld_en), .ref_ld_bit(ref_ld_bit),
    .ld_addr(ld_addr), .arr_rd_addr(arr_rd_addr), .src_rd_bit(src_rd_bit_u), .ref_rd_bit(ref_rd_bit_u),
    .res_rd_addr(res_rd_addr), .res_rd_pos(res_rd_pos_u), .ctl_word(ctl_word_u), .res_word(res_word_u),
    .cmp_pos(cmp_pos_u), .res_cnt(res_cnt_u), .busy(busy_u)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic load(input logic [63:0] s, input logic [63:0] r);
    for (int i = 0; i < LEN; i++) begin
      src_ld_en = 1'b1; ref_ld_en = 1'b1;
      ld_addr = PW'(i); src_ld_bit = s[i]; ref_ld_bit = r[i];
      step(1);
    end
    src_ld_en = 1'b0; ref_ld_en = 1'b0;
  endtask

  task automatic read_res(input int idx, output logic [PW-1:0] v);
    res_rd_addr = IW'(idx);
    step(1);
    v = res_rd_pos;
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    #2000000;
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      finish_run();
    end
  end

  initial begin
    logic [PW-1:0] v;
    step(3);
    rst = 1'b0;
    step(1);
    // R1 reset state
    chk("R1 ctl_word", ctl_word, 16'h0);
    chk("R1 res_word", res_word, 16'h0);
    chk("R1 cmp_pos", cmp_pos, 0);
    chk("R1 res_cnt", res_cnt, 0);
    chk("R1 busy", busy, 0);

    // table walk: full-pass mode
    for (int k = 0; k < NV; k++) begin
      load(V_MASK[k], 64'h0);
      inhibit = 1'b0;
      enable = 1'b1;
      step(LEN);
      chk("R6 not done early", ctl_word[13], 0);
      chk("R11 busy during scan", busy, 1);
      step(1);
      chk("R6 done", ctl_word[13], 1);
      chk("R2 enable status", ctl_word[15], 1);
      chk("R11 busy off", busy, 0);
      chk("R6 found", ctl_word[8], (V_CNT[k] > 0) ? 1 : 0);
      chk("R6 count", res_cnt, V_CNT[k]);
      chk("R5 end position", cmp_pos, LEN);
      if (V_CNT[k] > 0) begin
        read_res(0, v);
        chk("R6 first entry", v, V_FIRST[k]);
        read_res(V_CNT[k] - 1, v);
        chk("R6 last entry", v, V_LAST[k]);
        arr_rd_addr = PW'(V_FIRST[k]);
        step(1);
        chk("R8 ref kept", ref_rd_bit, 0);
        chk("R8 ref updated", ref_rd_bit_u, 1);
        chk("R8 src read", src_rd_bit, 1);
      end else begin
        chk("R7 no entries", res_cnt, 0);
      end
      enable = 1'b0;
      step(1);
      chk("R10 ctl cleared", ctl_word, 16'h0);
      chk("R10 pos cleared", cmp_pos, 0);
      chk("R10 cnt cleared", res_cnt, 0);
    end

    // R3/R4/R5 single-step mode, differences at 3 and 10
    load(64'h408, 64'h0);
    inhibit = 1'b1;
    enable = 1'b1;
    step(4);
    chk("R3 found not early", ctl_word[8], 0);
    step(1);
    chk("R3 found", ctl_word[8], 1);
    chk("R3 stopped", busy, 0);
    chk("R3 position", cmp_pos, 4);
    chk("R3 count", res_cnt, 1);
    read_res(0, v);
    chk("R3 entry 0", v, 3);
    enable = 1'b0;
    step(1);
    chk("R4 found cleared", ctl_word[8], 0);
    chk("R4 position kept", cmp_pos, 4);
    chk("R4 count kept", res_cnt, 1);
    enable = 1'b1;
    step(7);
    chk("R3 second not early", ctl_word[8], 0);
    step(1);
    chk("R3 second found", ctl_word[8], 1);
    chk("R3 second position", cmp_pos, 11);
    read_res(1, v);
    chk("R3 entry 1", v, 10);
    arr_rd_addr = PW'(3);
    step(1);
    chk("R8 single ref kept", ref_rd_bit, 0);
    chk("R8 single ref updated", ref_rd_bit_u, 1);
    enable = 1'b0;
    step(1);
    enable = 1'b1;
    step(54);
    chk("R5 done at end", ctl_word[13], 1);
    chk("R5 found last only", ctl_word[8], 0);
    chk("R5 end position", cmp_pos, LEN);
    enable = 1'b0;
    step(1);
    chk("R10 single cleared", ctl_word, 16'h0);

    // R9 buffer fill, halt and wrap: differences at 0..9
    load(64'h3FF, 64'h0);
    inhibit = 1'b0;
    enable = 1'b1;
    step(9);
    chk("R9 halted", busy, 0);
    chk("R9 full flag", res_word, 16'h2000);
    chk("R9 not done", ctl_word[13], 0);
    chk("R9 count full", res_cnt, DEP);
    chk("R9 position", cmp_pos, 8);
    enable = 1'b0;
    step(1);
    enable = 1'b1;
    step(57);
    chk("R9 done after wrap", ctl_word[13], 1);
    chk("R9 found", ctl_word[8], 1);
    chk("R9 count wrapped", res_cnt, 2);
    chk("R9 full cleared", res_word, 16'h0);
    read_res(0, v);
    chk("R9 entry 0", v, 8);
    read_res(1, v);
    chk("R9 entry 1", v, 9);
    read_res(2, v);
    chk("R9 entry 2 kept", v, 2);
    enable = 1'b0;
    step(1);

    // R7 clean pass leaves buffer alone
    load(64'h0, 64'h0);
    enable = 1'b1;
    step(LEN + 1);
    chk("R7 done", ctl_word[13], 1);
    chk("R7 found", ctl_word[8], 0);
    chk("R7 count", res_cnt, 0);
    read_res(0, v);
    chk("R7 entry 0 kept", v, 8);
    read_res(1, v);
    chk("R7 entry 1 kept", v, 9);
    enable = 1'b0;
    step(1);
    chk("R10 final cleared", ctl_word, 16'h0);

    finished = 1'b1;
    finish_run();
  end
endmodule